// File: doc/BRIEF.md
# Three-Phase PWM Timer with Repetition-Gated Compare Refresh

This block is a three-phase pulse-width timer built around a 12-bit counter that runs either as a sawtooth or as a triangle. A period compare and one compare per phase decide the waveform. Software writes all four compares into shadow registers, and those values reach the live comparators only on an update event. The update event is gated by an 8-bit repetition counter, so software controls how many counter turn-arounds pass between two refreshes of the duty cycles.

Each turn-around of the main counter is a counter event. In sawtooth mode that is the wrap at the top. In triangle mode there are two: the peak and the valley. The repetition counter steps down once per counter event and reloads itself from a software-written repetition value, so the refresh rate stays constant. Because the triangle mode produces two events per period, duties can be refreshed twice per period there. An interrupt pulse marks each update, and a separate debug pin toggles on every update so the refresh rate can be watched on a scope. A re-synchronization input restarts both counters from a known point.

Top module: `pwm_rep_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, `cnt`, `pwm_out`, `upd_irq` and `upd_dbg` are all zero, and every shadow and live compare and the repetition value are zero.
- R2: With `center_mode`=0 the counter steps up by one each cycle from 0 to the live period compare P. In the cycle after it shows P it shows 0, giving a period of P+1 cycles and one counter event per period (at P).
- R3: With `center_mode`=1 the counter climbs from 0 to P and then falls back to 0, giving a period of 2P cycles. The peak (P while rising) and the valley (0 while falling) are each a counter event.
- R4: A write is captured when `wr_en`=1 at a clock edge. `wr_sel` picks the target: 0 is the period compare, 1 is phase U, 2 is phase V, 3 is phase W, and 4 is the repetition value, which uses the low 8 bits of `wr_data`. Compare writes change only the shadow copy. The live copy keeps its value until the next update.
- R5: An update happens on a counter event in which the repetition counter is zero. That counter then reloads from the repetition value M; on any other counter event it decrements by one. Updates therefore come every M+1 counter events: every (M+1)(P+1) cycles in sawtooth mode and every (M+1)P cycles in triangle mode.
- R6: A new repetition value takes effect only at the next reload of the repetition counter. The interval to the update that follows a write keeps the old count.
- R7: `upd_irq` is high for exactly the cycle after the update edge. In that same cycle the new live compares are in use, and in sawtooth mode `cnt` reads 0.
- R8: `upd_dbg` inverts its level in each cycle where `upd_irq` is high and holds its level in every other cycle.
- R9: Phase output k (bit 0 = U, bit 1 = V, bit 2 = W) is high when its live compare C is nonzero and either `cnt` < C or C >= P. A compare of 0 gives a permanently low output, and a compare of P or more gives a permanently high output.
- R10: A cycle with `resync`=1 loads the counter to 0 rising and loads the repetition counter from the repetition value. That cycle generates neither a counter event nor an update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| center_mode | input | 1 | 0 = sawtooth counting, 1 = triangle counting |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_sel | input | 3 | Write target: 0 period, 1 U, 2 V, 3 W, 4 repetition value |
| wr_data | input | 12 | Write data |
| resync | input | 1 | Restart the counter and reload the repetition counter |
| cnt | output | 12 | Current counter value |
| pwm_out | output | 3 | Phase outputs, bit 0 = U, bit 1 = V, bit 2 = W |
| upd_irq | output | 1 | One-cycle pulse after each update |
| upd_dbg | output | 1 | Level that toggles on each update |

## Verification
The counting properties assume that `center_mode` stays put across the cycles they span, and that the period compare never shrinks below the running count while the counter climbs. The bench changes mode only between scenarios, and every change to the period compare arrives at a wrap in sawtooth mode. The properties that link events to interrupts assume that no counter event is hidden by `resync`. The bench therefore asserts `resync` for a single cycle away from any turn-around, and it measures intervals only between interrupts that follow undisturbed counting.

// File: rtl/pwm_rep_pkg.sv
package pwm_rep_pkg;

   // Counting direction of the main timer
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;

   // Upper limit accepted for the counter width parameter
   localparam int unsigned MAX_CNT_W = 16;

endpackage

// File: rtl/pwm_rep_counter.sv
module pwm_rep_counter
   import pwm_rep_pkg::*;
#(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             center,
   input  logic             resync,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_ev
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cnt_dir_e         dir_q, dir_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             turn;

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      turn  = 1'b0;
      if (!center) begin
         dir_d = DIR_UP;
         if (cnt_q >= period) begin
            turn  = 1'b1;
            cnt_d = '0;
         end else begin
            cnt_d = cnt_q + ONE;
         end
      end else if (dir_q == DIR_UP) begin
         if (cnt_q >= period) begin
            turn  = 1'b1;
            dir_d = DIR_DOWN;
            cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
         end else begin
            cnt_d = cnt_q + ONE;
         end
      end else begin
         if (cnt_q == '0) begin
            turn  = 1'b1;
            dir_d = DIR_UP;
            cnt_d = (period == '0) ? '0 : ONE;
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
      if (resync) begin
         turn  = 1'b0;
         cnt_d = '0;
         dir_d = DIR_UP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= DIR_UP;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   assign cnt     = cnt_q;
   assign wrap_ev = turn;

endmodule

// File: rtl/pwm_rep_gate.sv
module pwm_rep_gate #(
   parameter int unsigned REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap_ev,
   input  logic             resync,
   input  logic             mrep_we,
   input  logic [REP_W-1:0] mrep_wdata,
   output logic             upd,
   output logic [REP_W-1:0] rep_cnt,
   output logic [REP_W-1:0] mrep_q
);

   localparam logic [REP_W-1:0] ONE = REP_W'(1);

   logic [REP_W-1:0] rep_q;
   logic [REP_W-1:0] mrep_r;
   logic             rep_zero;

   assign rep_zero = (rep_q == '0);
   assign upd      = wrap_ev & rep_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mrep_r <= '0;
      end else if (mrep_we) begin
         mrep_r <= mrep_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_q <= '0;
      end else if (resync) begin
         rep_q <= mrep_r;
      end else if (wrap_ev) begin
         rep_q <= rep_zero ? mrep_r : rep_q - ONE;
      end
   end

   assign rep_cnt = rep_q;
   assign mrep_q  = mrep_r;

endmodule

// File: rtl/pwm_rep_cmp_bank.sv
module pwm_rep_cmp_bank #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned NCH   = 4,
   parameter int unsigned SEL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [CNT_W-1:0]     wr_data,
   input  logic                 upd,
   output logic [NCH*CNT_W-1:0] act_flat
);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [CNT_W-1:0] shadow_q;
      logic [CNT_W-1:0] live_q;
      logic             hit;

      assign hit = wr_en && (wr_sel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q <= '0;
         end else if (hit) begin
            shadow_q <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q <= '0;
         end else if (upd) begin
            live_q <= shadow_q;
         end
      end

      assign act_flat[i*CNT_W +: CNT_W] = live_q;
   end

endmodule

// File: rtl/pwm_rep_phase_out.sv
module pwm_rep_phase_out #(
   parameter int unsigned CNT_W = 12
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] period,
   output logic             level
);

   logic nonzero;
   logic below;
   logic saturate;

   assign nonzero  = (duty != '0);
   assign below    = (cnt < duty);
   assign saturate = (duty >= period);
   assign level    = nonzero & (below | saturate);

endmodule

// File: rtl/pwm_rep_timer.sv
module pwm_rep_timer #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned REP_W = 8,
   parameter int unsigned NPH   = 3,
   localparam int unsigned NCH     = NPH + 1,
   localparam int unsigned SEL_W   = $clog2(NPH + 2),
   localparam int unsigned REP_SEL = NPH + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             center_mode,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             resync,
   output logic [CNT_W-1:0] cnt,
   output logic [NPH-1:0]   pwm_out,
   output logic             upd_irq,
   output logic             upd_dbg
);

   // Elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > pwm_rep_pkg::MAX_CNT_W) begin : g_bad_cnt_w
      $error("pwm_rep_timer: CNT_W out of range");
   end
   if (REP_W < 1 || REP_W > CNT_W) begin : g_bad_rep_w
      $error("pwm_rep_timer: REP_W must be 1..CNT_W");
   end
   if (NPH < 1) begin : g_bad_nph
      $error("pwm_rep_timer: NPH must be at least 1");
   end

   logic                 wrap_ev;
   logic                 upd;
   logic [REP_W-1:0]     rep_cnt;
   logic [REP_W-1:0]     mrep_q;
   logic [NCH*CNT_W-1:0] act_flat;
   logic [CNT_W-1:0]     period_act;
   logic                 mrep_we;
   logic                 irq_q;
   logic                 dbg_q;

   assign period_act = act_flat[CNT_W-1:0];
   assign mrep_we    = wr_en && (wr_sel == SEL_W'(REP_SEL));

   pwm_rep_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .center  (center_mode),
      .resync  (resync),
      .period  (period_act),
      .cnt     (cnt),
      .wrap_ev (wrap_ev)
   );

   pwm_rep_gate #(.REP_W(REP_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .wrap_ev    (wrap_ev),
      .resync     (resync),
      .mrep_we    (mrep_we),
      .mrep_wdata (wr_data[REP_W-1:0]),
      .upd        (upd),
      .rep_cnt    (rep_cnt),
      .mrep_q     (mrep_q)
   );

   pwm_rep_cmp_bank #(.CNT_W(CNT_W), .NCH(NCH), .SEL_W(SEL_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .upd      (upd),
      .act_flat (act_flat)
   );

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      pwm_rep_phase_out #(.CNT_W(CNT_W)) u_out (
         .cnt    (cnt),
         .duty   (act_flat[(p+1)*CNT_W +: CNT_W]),
         .period (period_act),
         .level  (pwm_out[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         dbg_q <= 1'b0;
      end else begin
         irq_q <= upd;
         dbg_q <= dbg_q ^ upd;
      end
   end

   assign upd_irq = irq_q;
   assign upd_dbg = dbg_q;

endmodule

// File: rtl/pwm_rep_timer_chk.sv
module pwm_rep_timer_chk #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned REP_W = 8,
   parameter int unsigned NCH   = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 center_mode,
   input logic                 resync,
   input logic [CNT_W-1:0]     cnt,
   input logic                 wrap_ev,
   input logic [REP_W-1:0]     rep_cnt,
   input logic [REP_W-1:0]     mrep_q,
   input logic [NCH*CNT_W-1:0] act_flat,
   input logic                 upd_irq,
   input logic                 upd_dbg
);

   // R2
   edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!center_mode && !resync && cnt < act_flat[CNT_W-1:0])
      |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R5
   no_event_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_ev |=> !upd_irq);

   // R5
   busy_rep_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_ev && rep_cnt != '0) |=> !upd_irq);

   // R5
   rep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_ev && !resync && rep_cnt != '0)
      |=> rep_cnt == REP_W'($past(rep_cnt) - 1'b1));

   // R4
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_irq |-> $stable(act_flat));

   // R8
   dbg_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_irq |-> upd_dbg != $past(upd_dbg));

   // R8
   dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_irq |-> $stable(upd_dbg));

   // R10
   resync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (cnt == '0 && rep_cnt == $past(mrep_q) && !upd_irq));

endmodule

bind pwm_rep_timer pwm_rep_timer_chk #(
   .CNT_W(CNT_W),
   .REP_W(REP_W),
   .NCH  (NCH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .center_mode (center_mode),
   .resync      (resync),
   .cnt         (cnt),
   .wrap_ev     (wrap_ev),
   .rep_cnt     (rep_cnt),
   .mrep_q      (mrep_q),
   .act_flat    (act_flat),
   .upd_irq     (upd_irq),
   .upd_dbg     (upd_dbg)
);

// File: tb/pwm_rep_timer_tb.sv
`timescale 1ns/1ps
module pwm_rep_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        center_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [11:0] wr_data = '0;
   logic        resync = 1'b0;
   logic [11:0] cnt;
   logic [2:0]  pwm_out;
   logic        upd_irq;
   logic        upd_dbg;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pwm_rep_timer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .center_mode (center_mode),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .resync      (resync),
      .cnt         (cnt),
      .pwm_out     (pwm_out),
      .upd_irq     (upd_irq),
      .upd_dbg     (upd_dbg)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Called at a negedge; the write is captured at the next posedge
   task automatic wr(input int sel, input int data);
      wr_en   = 1'b1;
      wr_sel  = 3'(sel);
      wr_data = 12'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic cycles_to_irq(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!upd_irq && n < 1000);
   endtask

   // Count high cycles of each phase and the peak count over len cycles
   task automatic measure(input int len, output int hu, output int hv,
                          output int hw, output int peak);
      hu = 0; hv = 0; hw = 0; peak = 0;
      for (int k = 0; k < len; k++) begin
         hu += int'(pwm_out[0]);
         hv += int'(pwm_out[1]);
         hw += int'(pwm_out[2]);
         if (int'(cnt) > peak) peak = int'(cnt);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(cnt == 0,     "R1 cnt in reset", int'(cnt), 0);
      check(pwm_out == 0, "R1 pwm in reset", int'(pwm_out), 0);
      check(!upd_irq && !upd_dbg, "R1 irq/dbg in reset",
            int'({upd_irq, upd_dbg}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pwm_out == 0, "R1 pwm after reset", int'(pwm_out), 0);
   endtask

   task automatic t_edge();
      int n, hu, hv, hw, pk;
      bit d0;
      center_mode = 1'b0;
      wr(0, 9); wr(1, 3); wr(2, 0); wr(3, 12); wr(4, 0);
      repeat (30) @(negedge clk);
      cycles_to_irq(n);
      check(cnt == 0, "R7 cnt at irq in sawtooth", int'(cnt), 0);
      d0 = upd_dbg;
      cycles_to_irq(n);
      check(n == 10, "R2 sawtooth update interval M=0", n, 10);
      check(upd_dbg != d0, "R8 dbg toggles per update", int'(upd_dbg), int'(!d0));
      measure(10, hu, hv, hw, pk);
      check(pk == 9,  "R2 sawtooth peak", pk, 9);
      check(hu == 3,  "R9 U duty 3/10", hu, 3);
      check(hv == 0,  "R9 V zero duty", hv, 0);
      check(hw == 10, "R9 W above period full duty", hw, 10);
   endtask

   task automatic t_rep();
      int n;
      wr(4, 2);
      cycles_to_irq(n);
      cycles_to_irq(n);
      check(n == 30, "R5 sawtooth interval M=2", n, 30);
   endtask

   task automatic t_mrep_late();
      int n;
      wr(4, 0);
      cycles_to_irq(n);
      check(n + 1 == 30, "R6 old repetition kept until reload", n + 1, 30);
      cycles_to_irq(n);
      check(n == 10, "R6 new repetition after reload", n, 10);
   endtask

   task automatic t_preload();
      int n, hits, hu, hv, hw, pk;
      bit held;
      wr(4, 2);
      cycles_to_irq(n);
      cycles_to_irq(n);
      wr(1, 7);
      wr(3, 9);
      hits = 0;
      held = 1'b1;
      do begin
         @(negedge clk);
         if (!upd_irq && cnt == 5) begin
            hits++;
            if (pwm_out[0]) held = 1'b0;
         end
      end while (!upd_irq);
      check(held && hits == 3, "R4 shadow write not live before update",
            hits, 3);
      measure(10, hu, hv, hw, pk);
      check(hu == 7,  "R4 U live after update", hu, 7);
      check(hw == 10, "R9 W equal to period full duty", hw, 10);
   endtask

   task automatic t_resync();
      int n;
      wr(4, 3);
      cycles_to_irq(n);
      cycles_to_irq(n);
      repeat (5) @(negedge clk);
      resync = 1'b1;
      @(negedge clk);
      resync = 1'b0;
      check(cnt == 0 && !upd_irq, "R10 resync clears count, no update",
            int'(cnt) + 100 * int'(upd_irq), 0);
      cycles_to_irq(n);
      check(n == 40, "R10 first update after resync M=3", n, 40);
   endtask

   task automatic t_center();
      int n, hu, hv, hw, pk;
      @(negedge clk);
      center_mode = 1'b1;
      wr(4, 0);
      cycles_to_irq(n);
      cycles_to_irq(n);
      cycles_to_irq(n);
      check(cnt == 8 || cnt == 1, "R7 cnt at irq in triangle", int'(cnt), 8);
      cycles_to_irq(n);
      check(n == 9, "R3 triangle half-period update M=0", n, 9);
      cycles_to_irq(n);
      check(n == 9, "R3 triangle second half update", n, 9);
      measure(18, hu, hv, hw, pk);
      check(pk == 9,  "R3 triangle peak", pk, 9);
      check(hu == 13, "R9 U triangle duty 13/18", hu, 13);
      check(hw == 18, "R9 W triangle full duty", hw, 18);
      wr(4, 1);
      cycles_to_irq(n);
      cycles_to_irq(n);
      cycles_to_irq(n);
      check(n == 18, "R5 triangle interval M=1", n, 18);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_edge();
      t_rep();
      t_mrep_late();
      t_preload();
      t_resync();
      t_center();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule